// File: doc/BRIEF.md
# Packet RAM Direct Access Window

This block lets the CPU use the USB packet RAM as plain spare memory while the USB controller is switched off. It keeps an 11-bit byte pointer and an access-enable flag in two byte-wide registers. When the flag is set and the controller is disabled, the window is open. In that state each CPU read or write of the data register for the current mode reaches the RAM byte the pointer selects, and the pointer then steps forward by one.

When the window is closed, data-register accesses take the ordinary FIFO path to the controller, and the RAM port stays with the controller. In the window, the controller's own RAM address, its FIFO strobes and its endpoint selection play no part, so no controller state changes. Firmware loads a base address, sets the flag, and then streams bytes through the data register.

Top module: `pktram_window`

## Requirements
- R1: After reset the pointer is 0x000 and the enable flag is 0, so both pointer registers read 0x00.
- R2: Register select 0 reads and writes pointer bits 7:0. In register select 1, bit 7 is the enable flag and bits 2:0 are pointer bits 10:8, and bits 6:3 read as 0. A low-byte write leaves pointer bits 10:8 and the flag unchanged. Both registers can be read and written whatever the state of usb_en.
- R3: The window is open when the flag is 1 and usb_en is 0. The current-mode data register is select 2 when host_mode is 0 and select 3 when host_mode is 1. In the same cycle, a read of it with the window open drives ram_re=1 and ram_addr to the pointer, and cpu_rdata equals ram_rdata.
- R4: In the same cycle, a write of the current-mode data register with the window open drives ram_we=1, ram_addr to the pointer and ram_wdata to cpu_wdata.
- R5: At the clock edge that ends each window access, the pointer grows by one, and it wraps from 0x7FF to 0x000.
- R6: During a window access, ram_addr does not depend on ctl_ram_addr, and fifo_rd and fifo_wr stay 0.
- R7: With usb_en=1, a data-register access pulses fifo_rd or fifo_wr in the same cycle. A read returns fifo_rdata. The pointer does not change.
- R8: With the flag 0 and usb_en=0, data-register accesses take the FIFO path exactly as in R7.
- R9: An access to the data register of the other mode causes no RAM access and no FIFO strobe, leaves the pointer unchanged, and reads 0x00. cpu_rdata is 0x00 in any cycle without a read.
- R10: In any cycle without a window access, the RAM port outputs equal the ctl_ram_* inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_en | input | 1 | USB controller enabled; blocks the window |
| host_mode | input | 1 | 1 selects the host data register, 0 the device one |
| cpu_sel | input | 2 | CPU register select |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational |
| fifo_rd | output | 1 | Read strobe to the controller FIFO path |
| fifo_wr | output | 1 | Write strobe to the controller FIFO path (data on cpu_wdata) |
| fifo_rdata | input | 8 | Read data from the controller FIFO path |
| ctl_ram_addr | input | 11 | Controller RAM address |
| ctl_ram_we | input | 1 | Controller RAM write enable |
| ctl_ram_re | input | 1 | Controller RAM read enable |
| ctl_ram_wdata | input | 8 | Controller RAM write data |
| ram_addr | output | 11 | RAM port address |
| ram_we | output | 1 | RAM port write enable |
| ram_re | output | 1 | RAM port read enable |
| ram_wdata | output | 8 | RAM port write data |
| ram_rdata | input | 8 | RAM port read data, asynchronous |

## Verification
The bench mixes random data reads and writes with random pointer loads, and it changes usb_en, host_mode and the enable flag in phases. The open phases check that the RAM address follows the pointer and not the random controller address. The closed phases check that the same strobes move to the FIFO path. Accesses to the other mode's data register check that the wrong register has no effect. A directed run across 0x7FE..0x001 writes bytes and then reads them back, which separates correct wrap-around from an off-by-one pointer. Readback of the pointer after blocked accesses shows whether the pointer moved.

// File: rtl/pkw_pkg.sv
package pkw_pkg;

  localparam int PKW_PTR_W  = 11;
  localparam int PKW_DATA_W = 8;
  localparam int PKW_SEL_W  = 2;
  localparam int PKW_EN_BIT = 7;

  typedef enum logic [PKW_SEL_W-1:0] {
    SEL_PTR_LO    = 2'd0,
    SEL_PTR_HI    = 2'd1,
    SEL_DEV_DATA  = 2'd2,
    SEL_HOST_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_LO   = 3'd1,
    SRC_HI   = 3'd2,
    SRC_RAM  = 3'd3,
    SRC_FIFO = 3'd4
  } rd_src_e;

endpackage

// File: rtl/pkw_ptr_regs.sv
module pkw_ptr_regs #(
  parameter int PTR_W  = pkw_pkg::PKW_PTR_W,
  parameter int DATA_W = pkw_pkg::PKW_DATA_W,
  parameter int EN_BIT = pkw_pkg::PKW_EN_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step,
  output logic [PTR_W-1:0]  ptr,
  output logic              win_en,
  output logic [DATA_W-1:0] lo_view,
  output logic [DATA_W-1:0] hi_view
);

  localparam int HI_W = PTR_W - DATA_W;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    logic [PTR_W-1:0] one;
    one = '0;
    one[0] = 1'b1;
    return (p == {PTR_W{1'b1}}) ? '0 : p + one;
  endfunction

  function automatic logic [DATA_W-1:0] pack_hi(input logic en,
                                                input logic [HI_W-1:0] h);
    logic [DATA_W-1:0] b;
    b = '0;
    b[EN_BIT] = en;
    b[HI_W-1:0] = h;
    return b;
  endfunction

  logic [PTR_W-1:0] ptr_q;
  logic             en_q;
  logic [PTR_W-1:0] ptr_next;

  assign ptr_next = advance(ptr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      en_q  <= 1'b0;
    end else if (wr_lo) begin
      ptr_q[DATA_W-1:0] <= wdata;
    end else if (wr_hi) begin
      en_q               <= wdata[EN_BIT];
      ptr_q[PTR_W-1:DATA_W] <= wdata[HI_W-1:0];
    end else if (step) begin
      ptr_q <= ptr_next;
    end
  end

  assign ptr     = ptr_q;
  assign win_en  = en_q;
  assign lo_view = ptr_q[DATA_W-1:0];
  assign hi_view = pack_hi(en_q, ptr_q[PTR_W-1:DATA_W]);

  // R5
  ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_lo && !wr_hi && ptr_q != {PTR_W{1'b1}}) |=>
      (ptr_q == $past(ptr_q) + 1'b1));

  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_lo && !wr_hi && ptr_q == {PTR_W{1'b1}}) |=> (ptr_q == '0));

  // R2
  lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (ptr_q[PTR_W-1:DATA_W] == $past(ptr_q[PTR_W-1:DATA_W]))
              && (en_q == $past(en_q)));

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step || wr_lo || wr_hi) |=> ($stable(ptr_q) && $stable(en_q)));

endmodule

// File: rtl/pkw_access_dec.sv
module pkw_access_dec
  import pkw_pkg::*;
#(
  parameter int SEL_W = pkw_pkg::PKW_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             usb_en,
  input  logic             host_mode,
  input  logic             win_en,
  input  logic [SEL_W-1:0] cpu_sel,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  output logic             win_rd,
  output logic             win_wr,
  output logic             fifo_rd,
  output logic             fifo_wr,
  output logic             ptr_lo_wr,
  output logic             ptr_hi_wr,
  output rd_src_e          rd_src
);

  reg_sel_e sel;
  reg_sel_e mode_data;
  logic     open_win;
  logic     data_hit;

  assign sel       = reg_sel_e'(cpu_sel);
  assign mode_data = host_mode ? SEL_HOST_DATA : SEL_DEV_DATA;
  assign open_win  = win_en && !usb_en;
  assign data_hit  = (sel == mode_data);

  assign win_rd    = data_hit && cpu_rd && open_win;
  assign win_wr    = data_hit && cpu_wr && open_win;
  assign fifo_rd   = data_hit && cpu_rd && !open_win;
  assign fifo_wr   = data_hit && cpu_wr && !open_win;
  assign ptr_lo_wr = cpu_wr && (sel == SEL_PTR_LO);
  assign ptr_hi_wr = cpu_wr && (sel == SEL_PTR_HI);

  always_comb begin
    rd_src = SRC_NONE;
    if (cpu_rd) begin
      if (sel == SEL_PTR_LO)      rd_src = SRC_LO;
      else if (sel == SEL_PTR_HI) rd_src = SRC_HI;
      else if (data_hit)          rd_src = open_win ? SRC_RAM : SRC_FIFO;
    end
  end

  // R7
  usb_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usb_en |-> !(win_rd || win_wr));

  // R6
  fifo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd || win_wr) |-> !(fifo_rd || fifo_wr));

  // R9
  other_reg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel[SEL_W-1] && !data_hit) |-> !(win_rd || win_wr || fifo_rd || fifo_wr));

endmodule

// File: rtl/pkw_ram_mux.sv
module pkw_ram_mux #(
  parameter int PTR_W  = pkw_pkg::PKW_PTR_W,
  parameter int DATA_W = pkw_pkg::PKW_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_rd,
  input  logic              win_wr,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [PTR_W-1:0]  ctl_ram_addr,
  input  logic              ctl_ram_we,
  input  logic              ctl_ram_re,
  input  logic [DATA_W-1:0] ctl_ram_wdata,
  output logic [PTR_W-1:0]  ram_addr,
  output logic              ram_we,
  output logic              ram_re,
  output logic [DATA_W-1:0] ram_wdata
);

  logic steal;
  assign steal = win_rd || win_wr;

  always_comb begin
    if (steal) begin
      ram_addr  = ptr;
      ram_we    = win_wr;
      ram_re    = win_rd;
      ram_wdata = cpu_wdata;
    end else begin
      ram_addr  = ctl_ram_addr;
      ram_we    = ctl_ram_we;
      ram_re    = ctl_ram_re;
      ram_wdata = ctl_ram_wdata;
    end
  end

  // R4
  win_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr |-> (ram_we && ram_addr == ptr && ram_wdata == cpu_wdata));

  // R3
  win_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_rd |-> (ram_re && ram_addr == ptr));

  // R10
  ctl_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !steal |-> (ram_addr == ctl_ram_addr && ram_we == ctl_ram_we
                && ram_re == ctl_ram_re));

endmodule

// File: rtl/pktram_window.sv
module pktram_window
  import pkw_pkg::*;
#(
  parameter int PTR_W  = pkw_pkg::PKW_PTR_W,
  parameter int DATA_W = pkw_pkg::PKW_DATA_W,
  parameter int SEL_W  = pkw_pkg::PKW_SEL_W,
  parameter int EN_BIT = pkw_pkg::PKW_EN_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usb_en,
  input  logic              host_mode,
  input  logic [SEL_W-1:0]  cpu_sel,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              fifo_rd,
  output logic              fifo_wr,
  input  logic [DATA_W-1:0] fifo_rdata,
  input  logic [PTR_W-1:0]  ctl_ram_addr,
  input  logic              ctl_ram_we,
  input  logic              ctl_ram_re,
  input  logic [DATA_W-1:0] ctl_ram_wdata,
  output logic [PTR_W-1:0]  ram_addr,
  output logic              ram_we,
  output logic              ram_re,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);

  logic              win_rd, win_wr;
  logic              ptr_lo_wr, ptr_hi_wr;
  logic              win_en;
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] lo_view, hi_view;
  logic              step;
  rd_src_e           rd_src;

  assign step = win_rd || win_wr;

  pkw_access_dec #(.SEL_W(SEL_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .usb_en    (usb_en),
    .host_mode (host_mode),
    .win_en    (win_en),
    .cpu_sel   (cpu_sel),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .win_rd    (win_rd),
    .win_wr    (win_wr),
    .fifo_rd   (fifo_rd),
    .fifo_wr   (fifo_wr),
    .ptr_lo_wr (ptr_lo_wr),
    .ptr_hi_wr (ptr_hi_wr),
    .rd_src    (rd_src)
  );

  pkw_ptr_regs #(.PTR_W(PTR_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (ptr_lo_wr),
    .wr_hi   (ptr_hi_wr),
    .wdata   (cpu_wdata),
    .step    (step),
    .ptr     (ptr),
    .win_en  (win_en),
    .lo_view (lo_view),
    .hi_view (hi_view)
  );

  pkw_ram_mux #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_mux (
    .clk           (clk),
    .rst_n         (rst_n),
    .win_rd        (win_rd),
    .win_wr        (win_wr),
    .ptr           (ptr),
    .cpu_wdata     (cpu_wdata),
    .ctl_ram_addr  (ctl_ram_addr),
    .ctl_ram_we    (ctl_ram_we),
    .ctl_ram_re    (ctl_ram_re),
    .ctl_ram_wdata (ctl_ram_wdata),
    .ram_addr      (ram_addr),
    .ram_we        (ram_we),
    .ram_re        (ram_re),
    .ram_wdata     (ram_wdata)
  );

  always_comb begin
    unique case (rd_src)
      SRC_LO:   cpu_rdata = lo_view;
      SRC_HI:   cpu_rdata = hi_view;
      SRC_RAM:  cpu_rdata = ram_rdata;
      SRC_FIFO: cpu_rdata = fifo_rdata;
      default:  cpu_rdata = '0;
    endcase
  end

  // R9
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |-> (cpu_rdata == '0));

  // R3
  win_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_rd |-> (cpu_rdata == ram_rdata));

endmodule

// File: tb/test_pktram_window.sv
module test_pktram_window;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        usb_en = 1'b0, host_mode = 1'b0;
  logic [1:0]  cpu_sel = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        fifo_rd, fifo_wr;
  logic [7:0]  fifo_rdata = '0;
  logic [10:0] ctl_ram_addr = '0;
  logic        ctl_ram_we = 1'b0, ctl_ram_re = 1'b0;
  logic [7:0]  ctl_ram_wdata = '0;
  logic [10:0] ram_addr;
  logic        ram_we, ram_re;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata;

  logic [7:0]  ram_mem [0:2047];
  logic [7:0]  exp_mem [0:2047];
  logic [10:0] ptr_m;
  logic        en_m;
  logic        mode_usb, mode_host;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ram_rdata = ram_mem[ram_addr];
  always @(posedge clk) if (ram_we) ram_mem[ram_addr] <= ram_wdata;

  pktram_window i_pktram_window (
    .clk(clk), .rst_n(rst_n), .usb_en(usb_en), .host_mode(host_mode),
    .cpu_sel(cpu_sel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .fifo_rd(fifo_rd), .fifo_wr(fifo_wr), .fifo_rdata(fifo_rdata),
    .ctl_ram_addr(ctl_ram_addr), .ctl_ram_we(ctl_ram_we),
    .ctl_ram_re(ctl_ram_re), .ctl_ram_wdata(ctl_ram_wdata),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  function automatic logic [10:0] bump(input logic [10:0] p);
    return (p == 11'd2047) ? 11'd0 : 11'(int'(p) + 1);
  endfunction

  function automatic logic [7:0] hi_byte(input logic en, input logic [10:0] p);
    return 8'((en ? 128 : 0) + (int'(p) / 256));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] s, input logic r, input logic w,
                     input logic [7:0] d, input bit ctl_busy);
    logic        win, hit, other, wacc;
    logic [7:0]  e_rd;
    logic [10:0] p0;
    string       rq;
    @(negedge clk);
    usb_en = mode_usb; host_mode = mode_host;
    cpu_sel = s; cpu_rd = r; cpu_wr = w; cpu_wdata = d;
    ctl_ram_addr  = 11'($urandom);
    ctl_ram_we    = ctl_busy && ($urandom % 4 == 0);
    ctl_ram_re    = 1'($urandom);
    ctl_ram_wdata = 8'($urandom);
    fifo_rdata    = 8'($urandom);
    #1;
    win   = en_m && !mode_usb;
    hit   = (s == (mode_host ? 2'd3 : 2'd2));
    other = s[1] && !hit;
    wacc  = win && hit && (r || w);
    p0    = ptr_m;
    e_rd  = 8'h00; rq = "R9";
    if (r) begin
      if (s == 2'd0)      begin e_rd = ptr_m[7:0]; rq = "R2"; end
      else if (s == 2'd1) begin e_rd = hi_byte(en_m, ptr_m); rq = "R2"; end
      else if (hit && win) begin e_rd = exp_mem[ptr_m]; rq = "R3"; end
      else if (hit)       begin e_rd = fifo_rdata; rq = mode_usb ? "R7" : "R8"; end
    end
    chk(cpu_rdata == e_rd, rq, "cpu_rdata", cpu_rdata, e_rd);
    if (wacc) begin
      chk(ram_addr == ptr_m, "R6", "ram_addr", ram_addr, ptr_m);
      chk(ram_we == w && ram_re == r, w ? "R4" : "R3", "ram_we/re",
          {ram_we, ram_re}, {w, r});
      if (w) chk(ram_wdata == d, "R4", "ram_wdata", ram_wdata, d);
      chk(!fifo_rd && !fifo_wr, "R6", "fifo strobes", {fifo_rd, fifo_wr}, 0);
    end else begin
      chk(ram_addr == ctl_ram_addr && ram_we == ctl_ram_we && ram_re == ctl_ram_re
          && (!ctl_ram_we || ram_wdata == ctl_ram_wdata), other ? "R9" : "R10",
          "ram port", {ram_addr, ram_we, ram_re}, {ctl_ram_addr, ctl_ram_we, ctl_ram_re});
      chk(fifo_rd == (hit && r) && fifo_wr == (hit && w),
          other ? "R9" : (mode_usb ? "R7" : "R8"), "fifo strobes",
          {fifo_rd, fifo_wr}, {hit && r, hit && w});
    end
    @(posedge clk);
    if (wacc && w) exp_mem[p0] = d;
    else if (!wacc && ctl_ram_we) exp_mem[ctl_ram_addr] = ctl_ram_wdata;
    if (w && s == 2'd0) ptr_m[7:0] = d;
    else if (w && s == 2'd1) begin en_m = d[7]; ptr_m[10:8] = d[2:0]; end
    else if (wacc) ptr_m = bump(ptr_m);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 2048; i++) begin ram_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    ptr_m = '0; en_m = 1'b0; mode_usb = 1'b0; mode_host = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: reset state via readback
    cyc(2'd0, 1, 0, 0, 0);
    cyc(2'd1, 1, 0, 0, 0);
    chk(cpu_rdata == 8'h00, "R1", "hi after reset", cpu_rdata, 0);
    // R2: reserved bits read zero, low write keeps high part
    cyc(2'd1, 0, 1, 8'hFD, 0);
    cyc(2'd1, 1, 0, 0, 0);
    cyc(2'd0, 0, 1, 8'hA5, 0);
    cyc(2'd1, 1, 0, 0, 0);
    cyc(2'd0, 1, 0, 0, 0);
    // R5: wrap across 0x7FF with writes then read back
    cyc(2'd1, 0, 1, 8'h87, 0);
    cyc(2'd0, 0, 1, 8'hFE, 0);
    cyc(2'd2, 0, 1, 8'h11, 0);
    cyc(2'd2, 0, 1, 8'h22, 0);
    cyc(2'd2, 0, 1, 8'h33, 0);
    cyc(2'd0, 1, 0, 0, 0);
    cyc(2'd1, 1, 0, 0, 0);
    cyc(2'd1, 0, 1, 8'h87, 0);
    cyc(2'd0, 0, 1, 8'hFE, 0);
    for (int i = 0; i < 3; i++) cyc(2'd2, 1, 0, 0, 0);
    // R5: pointer value after the wrap, read through its register
    cyc(2'd0, 1, 0, 0, 0);
    chk(cpu_rdata == 8'h01, "R5", "ptr lo after wrap", cpu_rdata, 8'h01);
    // R9: host data register in device mode
    cyc(2'd3, 1, 0, 0, 0);
    cyc(2'd3, 0, 1, 8'h5A, 0);
    cyc(2'd0, 1, 0, 0, 0);
    // R7: controller enabled blocks the window
    mode_usb = 1'b1;
    cyc(2'd2, 1, 0, 0, 0);
    cyc(2'd2, 0, 1, 8'h77, 0);
    cyc(2'd0, 1, 0, 0, 0);
    cyc(2'd1, 1, 0, 0, 0);
    // R8: flag cleared with controller off
    mode_usb = 1'b0;
    cyc(2'd1, 0, 1, 8'h02, 0);
    cyc(2'd2, 1, 0, 0, 0);
    cyc(2'd2, 0, 1, 8'h66, 0);
    cyc(2'd0, 1, 0, 0, 0);
    // host mode window
    mode_host = 1'b1;
    cyc(2'd1, 0, 1, 8'h81, 0);
    cyc(2'd3, 0, 1, 8'hC3, 0);
    cyc(2'd2, 1, 0, 0, 0);
    // random phase
    for (int n = 0; n < 6000; n++) begin
      int op;
      logic [7:0] rv;
      logic [1:0] ds;
      if (n % 300 == 0) begin
        mode_usb  = ($urandom % 4 == 0);
        mode_host = 1'($urandom);
      end
      ds = mode_host ? 2'd3 : 2'd2;
      op = $urandom % 16;
      rv = 8'($urandom);
      case (op)
        0: cyc(2'd0, 0, 1, rv, 1);
        1: cyc(2'd1, 0, 1, {($urandom % 4 != 0), rv[6:0]}, 1);
        2: cyc(2'd0, 1, 0, 0, 1);
        3: cyc(2'd1, 1, 0, 0, 1);
        4, 5, 6, 7, 8: cyc(ds, 1, 0, 0, 1);
        9, 10, 11, 12: cyc(ds, 0, 1, rv, 1);
        13: cyc(~ds & 2'b11 | 2'b10, rv[0], !rv[0], rv, 1);
        default: cyc(2'($urandom), 0, 0, rv, 1);
      endcase
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule